// File: doc/BRIEF.md
# Fuzzy Rule Evaluation Sequencer

This block evaluates a list of min-max fuzzy rules stored as bytes in a synchronous memory. Every ordinary byte in the list is an unsigned offset from a base pointer. The offset selects either a fuzzy input or a fuzzy output byte, depending on the current phase. The byte value `0xFE` separates antecedent groups from consequent groups. The byte value `0xFF` ends the list.

While in the antecedent phase, the block keeps the smallest fetched input in an accumulator. While in the consequent phase, it raises each addressed output to the accumulator value. An output that is already at least as large is left untouched.

A host starts the block by loading the list pointer, base pointer, accumulator and phase, then pulsing `start_i`. The block shares one byte-wide memory port for all reads and writes. Read data is consumed two cycles after the read is issued. An interrupt request is sampled only at the start of each loop pass. When it is honoured, the block stops and exposes a state from which a new start resumes exactly where it left off.

Top module: `fuzzy_rule_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `susp_o` and `mem_req_o` are low.
- R2: `start_i` in idle loads rule pointer, base pointer, accumulator and phase (phase 0 = antecedent, 1 = consequent); `start_i` while busy has no effect on the run or its result.
- R3: The first busy cycle reads the byte at the rule pointer, and the pointer then advances. The fetched byte is used two cycles after its read, as offset: the first operand read, at base + byte, is issued in the third busy cycle. The next rule byte is read in the fourth busy cycle, at rule pointer + 1.
- R4: Each list byte, including `0xFE` and `0xFF`, costs one three-cycle loop pass. A run of N bytes is busy for exactly 2 + 3N cycles.
- R5: A `0xFE` or `0xFF` pass issues no operand access. The `0xFF` pass issues no prefetch. The reads in a run therefore number 1 + (ordinary bytes) + (bytes other than `0xFF`).
- R6: Each `0xFE` toggles the phase. A `0xFE` met in the consequent phase also sets the accumulator to `0xFF`.
- R7: In the antecedent phase, the accumulator takes the fetched input whenever that input is smaller.
- R8: In the consequent phase, the output at base + byte is written with the accumulator only when the output is smaller. A write always carries the accumulator value.
- R9: An interrupt request is honoured only in the first cycle of a loop pass. When it is honoured:
  - that pass does no work;
  - `busy_o` drops and `susp_o` pulses for one cycle;
  - `rule_ptr_o` addresses the byte not yet consumed;
  - restarting from `rule_ptr_o`, `acc_o` and `phase_o` gives the same writes and final outputs as an uninterrupted run.
- R10: `done_o` is high for one cycle, in the cycle after the last cycle of the `0xFF` pass. At that point `rule_ptr_o` is one past the `0xFF` byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or resume request |
| irq_i | input | 1 | Interrupt request, sampled at loop-pass start |
| rule_ptr_i | input | AW | Rule list pointer to load |
| base_ptr_i | input | AW | Base pointer to load |
| acc_i | input | DW | Accumulator to load |
| phase_i | input | 1 | Phase to load (1 = consequent) |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-list pulse |
| susp_o | output | 1 | One-cycle suspension pulse |
| rule_ptr_o | output | AW | Current rule list pointer |
| base_ptr_o | output | AW | Current base pointer |
| acc_o | output | DW | Current accumulator |
| phase_o | output | 1 | Current phase |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the access |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid the cycle after a read request |

## Verification
An interrupt request can land in the same cycle as the start of a separator pass. In that case the interrupt wins: the phase must not toggle, and the accumulator must not reset. Otherwise the resumed run would handle that separator twice.

The bench raises the request at a sweep of cycle offsets, so that it falls on ordinary, separator and consequent passes. It resumes from the exposed state each time. A scoreboard compares the ordered write stream and the final outputs against a reference evaluation. A second overlap is a start request arriving mid-run. This is judged by the unchanged cycle count and the unchanged write stream.

// File: rtl/fuzzy_rule_pkg.sv
package fuzzy_rule_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EVAL,
    ST_NEXT,
    ST_APPLY
  } seq_st_e;
endpackage

// File: rtl/fuzzy_rule_ctrl.sv
module fuzzy_rule_ctrl
  import fuzzy_rule_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    irq_i,
  input  logic    last_pass_i,
  output seq_st_e st_o,
  output logic    done_o,
  output logic    susp_o
);
  seq_st_e st_q, st_d;
  logic    done_d, susp_d;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    susp_d = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_FETCH;
      ST_FETCH: st_d = ST_WAIT;
      ST_WAIT:  st_d = ST_EVAL;
      ST_EVAL: begin
        if (irq_i) begin
          st_d   = ST_IDLE;
          susp_d = 1'b1;
        end else begin
          st_d = ST_NEXT;
        end
      end
      ST_NEXT:  st_d = ST_APPLY;
      ST_APPLY: begin
        if (last_pass_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_EVAL;
        end
      end
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      susp_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
      susp_o <= susp_d;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/fuzzy_rule_dpath.sv
module fuzzy_rule_dpath
  import fuzzy_rule_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_st_e       st_i,
  input  logic          start_i,
  input  logic          irq_i,
  input  logic [AW-1:0] rule_ptr_i,
  input  logic [AW-1:0] base_ptr_i,
  input  logic [DW-1:0] acc_i,
  input  logic          phase_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] rptr_o,
  output logic [AW-1:0] bptr_o,
  output logic [DW-1:0] acc_o,
  output logic          phase_o,
  output logic [DW-1:0] rd_o,
  output logic [DW-1:0] rx_o
);
  localparam logic [DW-1:0] END_B = '1;
  localparam logic [DW-1:0] SEP_B = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] ONE   = AW'(1);

  logic [AW-1:0] rptr_q, bptr_q;
  logic [DW-1:0] acc_q, rd_q, rx_q;
  logic          phase_q;
  logic          rx_mark;

  assign rx_mark = (rx_q == END_B) || (rx_q == SEP_B);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      bptr_q  <= '0;
      acc_q   <= '1;
      phase_q <= 1'b0;
      rd_q    <= '0;
      rx_q    <= '0;
    end else begin
      // read data is registered: consumed one cycle after it arrives
      rd_q <= rdata_i;
      unique case (st_i)
        ST_IDLE: begin
          if (start_i) begin
            rptr_q  <= rule_ptr_i;
            bptr_q  <= base_ptr_i;
            acc_q   <= acc_i;
            phase_q <= phase_i;
          end
        end
        ST_FETCH: rptr_q <= rptr_q + ONE;
        ST_EVAL: begin
          if (irq_i) begin
            // unconsumed byte must be fetched again on resume
            rptr_q <= rptr_q - ONE;
          end else begin
            rx_q <= rd_q;
            if (rd_q == SEP_B) begin
              phase_q <= ~phase_q;
              if (phase_q) acc_q <= '1;
            end
          end
        end
        ST_NEXT: if (rx_q != END_B) rptr_q <= rptr_q + ONE;
        ST_APPLY: begin
          if (!rx_mark && !phase_q && (rd_q < acc_q)) acc_q <= rd_q;
        end
        default: ;
      endcase
    end
  end

  assign rptr_o  = rptr_q;
  assign bptr_o  = bptr_q;
  assign acc_o   = acc_q;
  assign phase_o = phase_q;
  assign rd_o    = rd_q;
  assign rx_o    = rx_q;
endmodule

// File: rtl/fuzzy_rule_port.sv
module fuzzy_rule_port
  import fuzzy_rule_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  seq_st_e       st_i,
  input  logic          irq_i,
  input  logic [AW-1:0] rptr_i,
  input  logic [AW-1:0] bptr_i,
  input  logic [DW-1:0] acc_i,
  input  logic          phase_i,
  input  logic [DW-1:0] rd_i,
  input  logic [DW-1:0] rx_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  localparam logic [DW-1:0] END_B = '1;
  localparam logic [DW-1:0] SEP_B = {{(DW-1){1'b1}}, 1'b0};

  logic rd_mark, rx_mark;
  logic [AW-1:0] opnd_new, opnd_old;

  assign rd_mark  = (rd_i == END_B) || (rd_i == SEP_B);
  assign rx_mark  = (rx_i == END_B) || (rx_i == SEP_B);
  assign opnd_new = bptr_i + AW'(rd_i);
  assign opnd_old = bptr_i + AW'(rx_i);

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_i)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = rptr_i;
      end
      ST_EVAL: begin
        if (!irq_i && !rd_mark) begin
          mem_req_o  = 1'b1;
          mem_addr_o = opnd_new;
        end
      end
      ST_NEXT: begin
        if (rx_i != END_B) begin
          mem_req_o  = 1'b1;
          mem_addr_o = rptr_i;
        end
      end
      ST_APPLY: begin
        if (!rx_mark && phase_i && (rd_i < acc_i)) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = opnd_old;
          mem_wdata_o = acc_i;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fuzzy_rule_seq.sv
module fuzzy_rule_seq
  import fuzzy_rule_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          irq_i,
  input  logic [AW-1:0] rule_ptr_i,
  input  logic [AW-1:0] base_ptr_i,
  input  logic [DW-1:0] acc_i,
  input  logic          phase_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          susp_o,
  output logic [AW-1:0] rule_ptr_o,
  output logic [AW-1:0] base_ptr_o,
  output logic [DW-1:0] acc_o,
  output logic          phase_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam logic [DW-1:0] END_B = '1;

  seq_st_e       st;
  logic [DW-1:0] rd, rx;

  fuzzy_rule_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .irq_i      (irq_i),
    .last_pass_i(rx == END_B),
    .st_o       (st),
    .done_o     (done_o),
    .susp_o     (susp_o)
  );

  fuzzy_rule_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .st_i      (st),
    .start_i   (start_i),
    .irq_i     (irq_i),
    .rule_ptr_i(rule_ptr_i),
    .base_ptr_i(base_ptr_i),
    .acc_i     (acc_i),
    .phase_i   (phase_i),
    .rdata_i   (mem_rdata_i),
    .rptr_o    (rule_ptr_o),
    .bptr_o    (base_ptr_o),
    .acc_o     (acc_o),
    .phase_o   (phase_o),
    .rd_o      (rd),
    .rx_o      (rx)
  );

  fuzzy_rule_port #(.AW(AW), .DW(DW)) u_port (
    .st_i       (st),
    .irq_i      (irq_i),
    .rptr_i     (rule_ptr_o),
    .bptr_i     (base_ptr_o),
    .acc_i      (acc_o),
    .phase_i    (phase_o),
    .rd_i       (rd),
    .rx_i       (rx),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o)
  );

  assign busy_o = (st != ST_IDLE);
endmodule

// File: rtl/fuzzy_rule_seq_chk.sv
module fuzzy_rule_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          susp_o,
  input logic [AW-1:0] rule_ptr_o,
  input logic [DW-1:0] acc_o,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r9_susp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_o |-> (!busy_o && !done_o));

  a_r8_write_acc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && busy_o && mem_wdata_o == acc_o));

  a_r4_write_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  a_r3_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (rule_ptr_o == $past(rule_ptr_o) || rule_ptr_o == AW'($past(rule_ptr_o) + 1'b1)));
endmodule

bind fuzzy_rule_seq fuzzy_rule_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .susp_o     (susp_o),
  .rule_ptr_o (rule_ptr_o),
  .acc_o      (acc_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_wdata_o(mem_wdata_o)
);

// File: tb/fuzzy_rule_seq_test.sv
`timescale 1ns/1ps
module fuzzy_rule_seq_test;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [7:0] BASE = 8'h10;
  localparam logic [7:0] LIST_A = 8'h80;
  localparam logic [7:0] LIST_C = 8'hC0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 1'b0, irq_i = 1'b0, phase_i = 1'b0;
  logic [7:0] rule_ptr_i = '0, base_ptr_i = '0, acc_i = '0;
  logic busy_o, done_o, susp_o, phase_o, mem_req_o, mem_we_o;
  logic [7:0] rule_ptr_o, base_ptr_o, acc_o, mem_addr_o, mem_wdata_o;
  logic [7:0] mem_rdata = '0;

  logic [7:0] mem     [256];
  logic [7:0] ref_mem [256];

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  int n_tests = 0, n_fail = 0, n_reads = 0;

  always #5 clk = ~clk;

  fuzzy_rule_seq #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .irq_i(irq_i),
    .rule_ptr_i(rule_ptr_i), .base_ptr_i(base_ptr_i), .acc_i(acc_i), .phase_i(phase_i),
    .busy_o(busy_o), .done_o(done_o), .susp_o(susp_o),
    .rule_ptr_o(rule_ptr_o), .base_ptr_o(base_ptr_o), .acc_o(acc_o), .phase_o(phase_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  // synchronous memory, read data valid the cycle after the request
  always @(posedge clk) begin
    if (mem_req_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else          mem_rdata <= mem[mem_addr_o];
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes, counts reads
  always @(negedge clk) begin
    if (rst_n && mem_req_o && !mem_we_o) n_reads++;
    if (rst_n && mem_we_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        chk({mem_addr_o, mem_wdata_o} == {e.a, e.d}, "R8 write", {mem_addr_o, mem_wdata_o}, {e.a, e.d});
      end
    end
  end

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[BASE+0] = 8'h40; mem[BASE+1] = 8'h90; mem[BASE+2] = 8'h20;
    mem[BASE+3] = 8'hC0; mem[BASE+4] = 8'h70; mem[BASE+5] = 8'h55;
    mem[BASE+8'h21] = 8'h60;
    begin
      logic [7:0] la [17] = '{8'h00, 8'h01, 8'hFE, 8'h20, 8'h21, 8'hFE, 8'h02, 8'h03,
                              8'h04, 8'hFE, 8'h22, 8'h20, 8'hFE, 8'h05, 8'hFE, 8'h23, 8'hFF};
      for (int i = 0; i < 17; i++) mem[LIST_A+i] = la[i];
    end
    mem[LIST_C] = 8'hFF;
  endtask

  // reference evaluation; pushes expected writes, returns byte count and reads
  task automatic ref_eval(input logic [7:0] rp, output int nb, output int nrd,
                          output logic [7:0] facc, output logic fph);
    logic [7:0] a = 8'hFF, b, v;
    logic p = 1'b0;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    nb = 0; nrd = 1;
    forever begin
      b = ref_mem[8'(rp + nb)];
      nb++;
      if (b == 8'hFF) break;
      nrd++;
      if (b == 8'hFE) begin
        if (p) a = 8'hFF;
        p = ~p;
      end else begin
        nrd++;
        v = ref_mem[8'(BASE + b)];
        if (!p) begin
          if (v < a) a = v;
        end else if (v < a) begin
          ref_mem[8'(BASE + b)] = a;
          exp_q.push_back({8'(BASE + b), a});
        end
      end
    end
    facc = a; fph = p;
  endtask

  task automatic do_start(input logic [7:0] rp, input logic [7:0] ac, input logic ph);
    @(negedge clk);
    rule_ptr_i = rp; base_ptr_i = BASE; acc_i = ac; phase_i = ph; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_outputs(input string req);
    for (int i = 8'h20; i < 8'h28; i++)
      chk(mem[BASE+i] == ref_mem[BASE+i], req, mem[BASE+i], ref_mem[BASE+i]);
  endtask

  // plain run with cycle, read, done and pointer checks
  task automatic run(input logic [7:0] rp, input bit probe, input bit poke);
    int nb, nrd, cyc, r0;
    logic [7:0] facc;
    logic fph;
    ref_eval(rp, nb, nrd, facc, fph);
    r0 = n_reads;
    do_start(rp, 8'hFF, 1'b0);
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      cyc++;
      if (probe && cyc == 1)
        chk(mem_req_o && !mem_we_o && mem_addr_o == rp, "R3 fetch addr", mem_addr_o, rp);
      if (probe && cyc == 3)
        chk(mem_req_o && !mem_we_o && mem_addr_o == 8'(BASE + mem[rp]), "R3 operand addr",
            mem_addr_o, 8'(BASE + mem[rp]));
      if (probe && cyc == 4)
        chk(mem_req_o && !mem_we_o && mem_addr_o == 8'(rp + 1), "R3 prefetch addr",
            mem_addr_o, 8'(rp + 1));
      if (poke && cyc == 4) begin
        rule_ptr_i = LIST_C; acc_i = 8'h00; phase_i = 1'b1; start_i = 1'b1;
      end
      if (poke && cyc == 5) start_i = 1'b0;
      @(negedge clk);
    end
    chk(cyc == 2 + 3 * nb, poke ? "R2 start ignored, busy length" : "R4 busy length", cyc, 2 + 3 * nb);
    chk(done_o == 1'b1, "R10 done after last pass", done_o, 1);
    chk(n_reads - r0 == nrd, "R5 read count", n_reads - r0, nrd);
    chk(rule_ptr_o == 8'(rp + nb), "R10 final pointer", rule_ptr_o, 8'(rp + nb));
    chk(acc_o == facc && phase_o == fph, "R6 R7 final acc/phase", {acc_o, 7'b0, phase_o}, {facc, 7'b0, fph});
    @(negedge clk);
    chk(done_o == 1'b0, "R10 done one cycle", done_o, 0);
    chk(exp_q.size() == 0, "R8 pending writes", exp_q.size(), 0);
    check_outputs("R8 final outputs");
  endtask

  // run with one interrupt raised k cycles after start, then resume
  task automatic run_irq(input int k);
    int nb, nrd, cyc;
    bit seen = 0;
    logic [7:0] facc;
    logic fph;
    init_mem();
    ref_eval(LIST_A, nb, nrd, facc, fph);
    do_start(LIST_A, 8'hFF, 1'b0);
    for (int i = 0; i < k && busy_o; i++) @(negedge clk);
    if (busy_o) begin
      irq_i = 1'b1;
      cyc = 0;
      while (!susp_o && !done_o && cyc < 100) begin
        @(negedge clk);
        cyc++;
      end
      irq_i = 1'b0;
      seen = susp_o;
      chk(susp_o && !busy_o, "R9 suspended within a pass", susp_o, 1);
      chk(cyc <= 3, "R9 latency to pass start", cyc, 3);
      chk(rule_ptr_o >= LIST_A && rule_ptr_o < 8'(LIST_A + nb), "R9 saved pointer in list",
          rule_ptr_o, LIST_A);
      if (seen) do_start(rule_ptr_o, acc_o, phase_o);
    end
    cyc = 0;
    while (busy_o && cyc < 5000) begin
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    chk(exp_q.size() == 0, "R9 resumed writes complete", exp_q.size(), 0);
    chk(acc_o == facc && phase_o == fph, "R9 resumed acc/phase", {acc_o, 7'b0, phase_o},
        {facc, 7'b0, fph});
    check_outputs("R9 resumed outputs");
  endtask

  initial begin : watchdog
    #1500000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    init_mem();
    #1;
    chk(!busy_o && !done_o && !susp_o && !mem_req_o, "R1 reset state",
        {busy_o, done_o, susp_o, mem_req_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_o, "R1 idle after reset", {busy_o, mem_req_o}, 0);

    run(LIST_A, 1'b1, 1'b0);   // R3 R4 R5 R6 R7 R8 R10
    run(LIST_A, 1'b0, 1'b0);   // R8: outputs already high, no writes
    run(LIST_C, 1'b0, 1'b0);   // R5: end-only list
    init_mem();
    run(LIST_A, 1'b0, 1'b1);   // R2: start while busy
    for (int k = 2; k < 52; k += 3) run_irq(k);   // R9

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule